// File: doc/BRIEF.md
# Per-Page ROM Bank Selector

This block sits beside the instruction fetch path and tracks which of up to four 4K-word ROM banks is visible in each 4K page of the address space. It watches each executed 10-bit instruction together with the page number of the address it came from. When one of the four bank-select opcodes executes, it records the requested bank for that page only. The processor treats these opcodes as no-operations. The block only observes the instruction stream and never stalls or alters it.

A second page input carries the page that address generation is currently reaching, and the block answers with that page's stored bank number. The answer is combinational, so a bank change shows on the very next fetch. Standby leaves every selection as it is. Deep sleep, power-down and reset all return every page to the first bank. A per-page parameter gives the highest bank index that each page implements, and any request above that index is held to it.

Top module: `page_bank_sel`

## Requirements
- R1: After reset, every page reports bank code 0 on `bank_o`. The code is the bank number minus one, so 0..3 stand for banks 1..4.
- R2: While `insn_valid_i` is high, the opcodes 0x100, 0x180, 0x140 and 0x1C0 request bank codes 0, 1, 2 and 3. The request changes only the page given on `fetch_page_i`, and the new code appears on `bank_o` from the next clock edge.
- R3: Any other instruction value, and any opcode presented while `insn_valid_i` is low, leaves every page's bank code unchanged.
- R4: Pages 0, 1 and 2 ignore bank-select opcodes and always report code 0.
- R5: Each page keeps its own register. In particular, the two pages of one port (for example 8 and 9) are independent of each other.
- R6: `standby_i`, whether high or low, has no effect on any stored bank code.
- R7: `deep_sleep_i` high at a clock edge returns every page to code 0. This takes priority over a bank-select opcode in the same cycle.
- R8: For page p, a request above the highest code set in bits [2p+1:2p] of `MAX_BANK_MAP` is stored as that highest code.
- R9: `bank_o` follows `addr_page_i` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | One-cycle strobe marking an executed instruction |
| insn_i | input | 10 | Executed instruction word |
| fetch_page_i | input | 4 | Page the instruction was fetched from |
| standby_i | input | 1 | Standby indication (no effect on state) |
| deep_sleep_i | input | 1 | Deep sleep or power-down event |
| addr_page_i | input | 4 | Page currently being addressed |
| bank_o | output | 2 | Bank code for `addr_page_i` |

## Verification
The bench builds the block with a mixed `MAX_BANK_MAP`. Page 7 has one bank, page 5 has two, page 12 has three and all other pages have four. This brings the clamping paths of R8 within reach next to unclamped pages. The rest of the map stays at its default, so the pair 8/9 and the system pages 0 to 2 show R4 and R5 with full four-bank ranges.

// File: rtl/page_bank_pkg.sv
package page_bank_pkg;
  localparam int INSN_W = 10;
  localparam int BANK_W = 2;

  typedef logic [BANK_W-1:0] bank_t;

  localparam logic [INSN_W-1:0] OP_BANK0 = 10'h100;
  localparam logic [INSN_W-1:0] OP_BANK1 = 10'h180;
  localparam logic [INSN_W-1:0] OP_BANK2 = 10'h140;
  localparam logic [INSN_W-1:0] OP_BANK3 = 10'h1C0;

  function automatic bank_t bank_clamp(input bank_t req, input bank_t top);
    return (req > top) ? top : req;
  endfunction
endpackage

// File: rtl/page_bank_dec.sv
module page_bank_dec
  import page_bank_pkg::*;
(
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              hit_o,
  output bank_t             bank_o
);
  always_comb begin
    hit_o  = valid_i;
    bank_o = '0;
    unique case (insn_i)
      OP_BANK0: bank_o = 2'd0;
      OP_BANK1: bank_o = 2'd1;
      OP_BANK2: bank_o = 2'd2;
      OP_BANK3: bank_o = 2'd3;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/page_bank_regs.sv
module page_bank_regs
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES    = 16,
  parameter int FIRST_BANKED = 3,
  parameter logic [NUM_PAGES*BANK_W-1:0] MAX_BANK_MAP = '1,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        wr_i,
  input  logic [PAGE_W-1:0]           wr_page_i,
  input  bank_t                       wr_bank_i,
  output logic [NUM_PAGES*BANK_W-1:0] banks_o
);
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    if (p < FIRST_BANKED) begin : g_fixed
      assign banks_o[p*BANK_W +: BANK_W] = '0;
    end else begin : g_banked
      localparam bank_t TOP = MAX_BANK_MAP[p*BANK_W +: BANK_W];
      bank_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= '0;
        else if (clr_i)                              q <= '0;
        else if (wr_i && wr_page_i == PAGE_W'(p))    q <= bank_clamp(wr_bank_i, TOP);
      end
      assign banks_o[p*BANK_W +: BANK_W] = q;
    end
  end
endmodule

// File: rtl/page_bank_mux.sv
module page_bank_mux
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic [NUM_PAGES*BANK_W-1:0] banks_i,
  input  logic [PAGE_W-1:0]           sel_i,
  output bank_t                       bank_o
);
  always_comb begin
    bank_o = '0;
    for (int p = 0; p < NUM_PAGES; p++)
      if (sel_i == PAGE_W'(p)) bank_o = banks_i[p*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/page_bank_sel.sv
module page_bank_sel
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES    = 16,
  parameter int FIRST_BANKED = 3,
  parameter logic [NUM_PAGES*BANK_W-1:0] MAX_BANK_MAP = '1,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [PAGE_W-1:0] fetch_page_i,
  input  logic              standby_i,
  input  logic              deep_sleep_i,
  input  logic [PAGE_W-1:0] addr_page_i,
  output logic [BANK_W-1:0] bank_o
);
  logic                        hit;
  bank_t                       req_bank;
  logic [NUM_PAGES*BANK_W-1:0] banks;
  logic                        standby_unused;

  // standby keeps state by design; the input is observed only
  assign standby_unused = standby_i;

  page_bank_dec u_dec (
    .valid_i (insn_valid_i),
    .insn_i  (insn_i),
    .hit_o   (hit),
    .bank_o  (req_bank)
  );

  page_bank_regs #(
    .NUM_PAGES    (NUM_PAGES),
    .FIRST_BANKED (FIRST_BANKED),
    .MAX_BANK_MAP (MAX_BANK_MAP)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (deep_sleep_i),
    .wr_i      (hit),
    .wr_page_i (fetch_page_i),
    .wr_bank_i (req_bank),
    .banks_o   (banks)
  );

  page_bank_mux #(.NUM_PAGES(NUM_PAGES)) u_mux (
    .banks_i (banks),
    .sel_i   (addr_page_i),
    .bank_o  (bank_o)
  );
endmodule

// File: rtl/page_bank_sel_chk.sv
module page_bank_sel_chk
  import page_bank_pkg::*;
#(
  parameter int NUM_PAGES    = 16,
  parameter int FIRST_BANKED = 3,
  parameter logic [NUM_PAGES*BANK_W-1:0] MAX_BANK_MAP = '1,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              insn_valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [PAGE_W-1:0] fetch_page_i,
  input logic              deep_sleep_i,
  input logic [PAGE_W-1:0] addr_page_i,
  input logic [BANK_W-1:0] bank_o
);
  function automatic bank_t top_of(input logic [PAGE_W-1:0] p);
    return MAX_BANK_MAP[int'(p)*BANK_W +: BANK_W];
  endfunction

  logic is_op;
  assign is_op = (insn_i == OP_BANK0) || (insn_i == OP_BANK1) ||
                 (insn_i == OP_BANK2) || (insn_i == OP_BANK3);

  a_r4_system_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_page_i) < FIRST_BANKED) |-> bank_o == '0);

  a_r7_sleep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_sleep_i |=> bank_o == '0);

  a_r8_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_o <= top_of(addr_page_i));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deep_sleep_i && !(insn_valid_i && is_op)) ##1 $stable(addr_page_i)
      |-> $stable(bank_o));

  a_r2_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && is_op && !deep_sleep_i && int'(fetch_page_i) >= FIRST_BANKED)
      ##1 (addr_page_i == $past(fetch_page_i))
      |-> bank_o == bank_clamp({$past(insn_i[6]), $past(insn_i[7])}, top_of(addr_page_i)));
endmodule

bind page_bank_sel page_bank_sel_chk #(
  .NUM_PAGES    (NUM_PAGES),
  .FIRST_BANKED (FIRST_BANKED),
  .MAX_BANK_MAP (MAX_BANK_MAP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .insn_valid_i (insn_valid_i),
  .insn_i       (insn_i),
  .fetch_page_i (fetch_page_i),
  .deep_sleep_i (deep_sleep_i),
  .addr_page_i  (addr_page_i),
  .bank_o       (bank_o)
);

// File: tb/sim_page_bank_sel.sv
`timescale 1ns/1ps
module sim_page_bank_sel;
  localparam int NP = 16;
  localparam logic [31:0] MAP = 32'hFEFF_37FF; // p5 top 1, p7 top 0, p12 top 2

  logic       clk_i = 0, rst_ni = 0, insn_valid_i = 0, standby_i = 0, deep_sleep_i = 0;
  logic [9:0] insn_i = 0;
  logic [3:0] fetch_page_i = 0, addr_page_i = 0;
  logic [1:0] bank_o;

  int total = 0, bad = 0;
  logic [1:0] model [NP];

  always #5 clk_i = ~clk_i;

  page_bank_sel #(.NUM_PAGES(NP), .FIRST_BANKED(3), .MAX_BANK_MAP(MAP)) u0 (.*);

  function automatic logic [1:0] top_of(int p);
    return MAP[p*2 +: 2];
  endfunction

  function automatic int code_of(logic [9:0] w);
    case (w)
      10'h100: return 0;
      10'h180: return 1;
      10'h140: return 2;
      10'h1C0: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic check_page(int p, string req);
    addr_page_i = 4'(p);
    #1;
    total++;
    if (bank_o !== model[p]) begin
      bad++;
      $display("FAIL %s page=%0d actual=%0d expected=%0d", req, p, bank_o, model[p]);
    end
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < NP; p++) check_page(p, req);
  endtask

  // one clock with the given inputs, model updated per R2/R3/R4/R7/R8
  task automatic step(logic v, logic [9:0] w, int pg, logic ds, logic sb);
    int c;
    @(negedge clk_i);
    insn_valid_i = v; insn_i = w; fetch_page_i = 4'(pg);
    deep_sleep_i = ds; standby_i = sb;
    @(posedge clk_i);
    c = code_of(w);
    if (ds) for (int p = 0; p < NP; p++) model[p] = 0;
    else if (v && c >= 0 && pg >= 3)
      model[pg] = (2'(c) > top_of(pg)) ? top_of(pg) : 2'(c);
    @(negedge clk_i);
    insn_valid_i = 0; deep_sleep_i = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] ops [4] = '{10'h100, 10'h180, 10'h140, 10'h1C0};
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++) model[p] = 0;
    #22 rst_ni = 1;
    check_all("R1");

    // R2: each opcode on page 10
    for (int k = 0; k < 4; k++) begin step(1, ops[k], 10, 0, 0); check_page(10, "R2"); end
    // R9: output follows addr_page without a clock
    step(1, 10'h180, 3, 0, 0);
    addr_page_i = 3; #1; addr_page_i = 10; #1;
    check_page(10, "R9"); check_page(3, "R9");
    // R4: system pages
    for (int p = 0; p < 3; p++) begin step(1, 10'h1C0, p, 0, 0); check_page(p, "R4"); end
    // R5: pair 8/9
    step(1, 10'h140, 8, 0, 0); check_page(8, "R5"); check_page(9, "R5");
    step(1, 10'h180, 9, 0, 0); check_page(8, "R5"); check_page(9, "R5");
    // R3: non-opcode and opcode without strobe
    step(1, 10'h101, 8, 0, 0); check_page(8, "R3");
    step(0, 10'h1C0, 9, 0, 0); check_page(9, "R3");
    // R8: clamping
    step(1, 10'h1C0, 5, 0, 0);  check_page(5, "R8");
    step(1, 10'h180, 7, 0, 0);  check_page(7, "R8");
    step(1, 10'h1C0, 12, 0, 0); check_page(12, "R8");
    step(1, 10'h180, 12, 0, 0); check_page(12, "R8");
    // R6: standby toggles keep state
    step(0, 10'h000, 0, 0, 1); step(0, 10'h000, 0, 0, 1); step(0, 10'h000, 0, 0, 0);
    check_all("R6");
    // R7: deep sleep with a colliding opcode
    step(1, 10'h1C0, 11, 1, 0);
    check_all("R7");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      int pg = $urandom_range(0, NP-1);
      logic [9:0] w = (r < 65) ? ops[$urandom_range(0, 3)] : 10'($urandom);
      step(r < 90, w, pg, r >= 97, 1'($urandom_range(0, 1)));
      check_page($urandom_range(0, NP-1), "R2");
      check_page(pg, "R8");
    end
    check_all("R5");

    // R1: async reset mid-run
    step(1, 10'h1C0, 14, 0, 0);
    rst_ni = 0; #3; rst_ni = 1;
    for (int p = 0; p < NP; p++) model[p] = 0;
    check_all("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule